// File: doc/BRIEF.md
# Linked-List XOR and Copy DMA Channel

This block is one DMA channel that works through a chain of descriptors kept in memory. Each descriptor names a destination buffer, up to eight source buffers and a length. In copy mode the channel moves source 0 to the destination. In XOR mode each destination word is the bitwise XOR of the matching word in every source that the descriptor enables. When a descriptor is done, the channel writes its status word back with the ownership bit cleared. It then follows the next pointer and stops when that pointer is zero.

Software sets up the block through a four-word register port. It writes a mode into the config register, writes the address of the first descriptor into the head register, and writes 1 to bit 0 of the activation register. One word-wide memory port with a request/acknowledge handshake carries both the descriptor fetches and the data traffic. When the channel reaches the end of a chain it raises a one-cycle event pulse, which the interrupt logic consumes.

The controller is a six-state machine:
- ST_IDLE: waiting. An accepted activate write takes it to ST_FETCH.
- ST_FETCH: reads the descriptor words in order. It goes back to ST_IDLE if word 0 is not owned by hardware. It goes to ST_STAT_WR for a zero length, to ST_DST_WR when no source is enabled, and to ST_SRC_RD otherwise.
- ST_SRC_RD: reads one enabled source word and folds it into the accumulator. It stays in ST_SRC_RD for the next enabled source, or moves to ST_DST_WR after the last one.
- ST_DST_WR: writes the accumulated word. It goes to ST_STAT_WR after the last word, and back to ST_SRC_RD or ST_DST_WR otherwise.
- ST_STAT_WR: returns ownership of the descriptor, then moves to ST_LINK.
- ST_LINK: goes to ST_FETCH of the next descriptor, or to ST_IDLE at a zero link.

Top module: `xorchain_dma`

## Requirements
- R1: After reset the channel is idle: activation read is 0, current-descriptor read is 0, mem_req is low and eoc is low.
- R2: Writing 1 to bit 0 of register 1 while idle starts the channel at the head register's address. While the channel works, register 1 reads with bits [5:4] = 01, and it reads 00 once the channel is idle. No memory request is made while idle.
- R3: Descriptor layout in word addresses from its base:
  - +0 status, whose bit 31 means hardware-owned
  - +1 command, whose bit i enables source i
  - +2 next pointer
  - +3 length in bytes, where bits [1:0] are ignored
  - +4 destination
  - +5 to +12 sources 0 to 7
- R4: When config bits [2:0] are not 001 (copy mode), destination word j equals source 0 word j for length/4 words.
- R5: When config bits [2:0] = 001 (XOR mode), destination word j is the XOR of word j of every source whose command bit is set. An empty bitmap writes zeros.
- R6: On completion the status word is written back with bit 31 cleared and the other bits kept.
- R7: The channel follows non-zero next pointers and stops at a zero pointer. Register 3 then holds the address of the last descriptor handled.
- R8: eoc is a one-cycle pulse, given once per chain, in the first idle cycle.
- R9: A fetched status word with bit 31 clear stops the chain at once. Nothing is written to memory, eoc pulses, and register 3 points at that descriptor.
- R10: While the channel is busy, writes to the config, head and activation registers are ignored.
- R11: When config bit 3 is set, descriptor words are byte-reversed on fetch and the status write-back is byte-reversed as well. Data words are not swapped.
- R12: A zero length makes no data access, but the status is still written back.
- R13: Once raised, mem_req holds with a stable address, direction and write data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 config, 1 activation, 2 head, 3 current descriptor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| eoc | output | 1 | End-of-chain event pulse |

## Verification
The hardest case to reach from the ports is a register write that arrives while a chain is running. If that write were accepted, it would corrupt the mode or restart the walk. The bench issues such writes while a three-descriptor XOR chain is in progress. It then reads the registers back, checks the end-of-chain count and checks the memory image. A wrong acceptance shows up as copy-mode data or as an extra chain. Unowned descriptors, zero lengths, empty source bitmaps and byte-swapped descriptors each get their own chain. A behavioural model checks every memory write on the clock where it happens.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SRC_RD,
        ST_DST_WR,
        ST_STAT_WR,
        ST_LINK
    } xc_state_e;

    // words in a descriptor ahead of the source address list
    localparam int DESC_HDR = 5;
    localparam logic [2:0] MODE_XOR = 3'b001;

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/xc_srcpick.sv
module xc_srcpick #(
    parameter int NSRC = 8,
    localparam int IW = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0] mask,
    input  logic [IW-1:0]   from,
    output logic            found,
    output logic [IW-1:0]   idx
);
    // lowest enabled source at or above 'from'
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) >= from)) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xc_regs.sv
module xc_regs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy,
    input  logic [AW-1:0] cur_desc,
    output logic [2:0]    mode,
    output logic          swap,
    output logic [AW-1:0] head,
    output logic          start
);
    logic [3:0]  cfg_q;
    logic [31:0] head_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            head_q <= '0;
        end else if (reg_wr && !busy) begin
            if (reg_addr == 2'd0) cfg_q  <= reg_wdata[3:0];
            if (reg_addr == 2'd2) head_q <= reg_wdata;
        end
    end

    assign start = reg_wr && !busy && (reg_addr == 2'd1) && reg_wdata[0];
    assign mode  = cfg_q[2:0];
    assign swap  = cfg_q[3];
    assign head  = head_q[AW-1:0];

    always_comb begin
        unique case (reg_addr)
            2'd0: reg_rdata = {28'b0, cfg_q};
            2'd1: reg_rdata = {26'b0, (busy ? 2'b01 : 2'b00), 4'b0};
            2'd2: reg_rdata = head_q;
            default: reg_rdata = {{(32-AW){1'b0}}, cur_desc};
        endcase
    end

    // R10
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> (cfg_q == $past(cfg_q)) && (head_q == $past(head_q)));
endmodule

// File: rtl/xc_engine.sv
module xc_engine import xc_pkg::*; #(
    parameter int AW   = 16,
    parameter int NSRC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] head,
    input  logic [2:0]    mode,
    input  logic          swap,
    output logic          busy,
    output logic [AW-1:0] cur_desc,
    output logic          eoc,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);
    localparam int NW = DESC_HDR + NSRC;
    localparam int FW = $clog2(NW);
    localparam int IW = $clog2(NSRC + 1);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    xc_state_e state, nstate;

    logic [FW-1:0]   fi;
    logic [AW-1:0]   cur, widx, d_nw, d_dst;
    logic [AW-1:0]   d_src [NSRC];
    logic [31:0]     d_stat, d_next, acc, wd;
    logic [NSRC-1:0] d_cmd, smask;
    logic [IW-1:0]   sidx, first_idx, after_idx;
    logic            first_found, after_found, eoc_q, last_fetch, last_word;

    assign wd         = swap ? bswap32(mem_rdata) : mem_rdata;
    assign smask      = (mode == MODE_XOR) ? d_cmd : NSRC'(1);
    assign last_fetch = (fi == FW'(NW - 1));
    assign last_word  = ((widx + 1'b1) == d_nw);

    xc_srcpick #(.NSRC(NSRC)) u_first (
        .mask(smask), .from('0), .found(first_found), .idx(first_idx));
    xc_srcpick #(.NSRC(NSRC)) u_after (
        .mask(smask), .from(sidx + 1'b1), .found(after_found), .idx(after_idx));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (start) nstate = ST_FETCH;
            ST_FETCH:
                if (mem_ack) begin
                    if ((fi == '0) && !wd[31])  nstate = ST_IDLE;
                    else if (last_fetch) begin
                        if (d_nw == '0)         nstate = ST_STAT_WR;
                        else if (!first_found)  nstate = ST_DST_WR;
                        else                    nstate = ST_SRC_RD;
                    end
                end
            ST_SRC_RD: if (mem_ack) nstate = after_found ? ST_SRC_RD : ST_DST_WR;
            ST_DST_WR:
                if (mem_ack) begin
                    if (last_word)        nstate = ST_STAT_WR;
                    else if (first_found) nstate = ST_SRC_RD;
                    else                  nstate = ST_DST_WR;
                end
            ST_STAT_WR: if (mem_ack) nstate = ST_LINK;
            ST_LINK:    nstate = (d_next == '0) ? ST_IDLE : ST_FETCH;
            default:    nstate = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi <= '0; cur <= '0; widx <= '0; acc <= '0; sidx <= '0;
            d_stat <= '0; d_cmd <= '0; d_next <= '0; d_nw <= '0; d_dst <= '0;
            for (int k = 0; k < NSRC; k++) d_src[k] <= '0;
            eoc_q <= 1'b0;
        end else begin
            eoc_q <= 1'b0;
            unique case (state)
                ST_IDLE:
                    if (start) begin
                        cur <= head;
                        fi  <= '0;
                    end
                ST_FETCH:
                    if (mem_ack) begin
                        fi <= fi + 1'b1;
                        case (fi)
                            FW'(0): d_stat <= wd;
                            FW'(1): d_cmd  <= wd[NSRC-1:0];
                            FW'(2): d_next <= wd;
                            FW'(3): d_nw   <= wd[AW+1:2];
                            FW'(4): d_dst  <= wd[AW-1:0];
                            default: ;
                        endcase
                        for (int k = 0; k < NSRC; k++)
                            if (fi == FW'(DESC_HDR + k)) d_src[k] <= wd[AW-1:0];
                        if ((fi == '0) && !wd[31]) eoc_q <= 1'b1;
                        widx <= '0;
                        acc  <= '0;
                        sidx <= first_idx;
                    end
                ST_SRC_RD:
                    if (mem_ack) begin
                        acc  <= acc ^ mem_rdata;
                        sidx <= after_idx;
                    end
                ST_DST_WR:
                    if (mem_ack) begin
                        acc  <= '0;
                        widx <= widx + 1'b1;
                        sidx <= first_idx;
                    end
                ST_STAT_WR: ;
                ST_LINK: begin
                    fi <= '0;
                    if (d_next == '0) eoc_q <= 1'b1;
                    else              cur   <= d_next[AW-1:0];
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_FETCH:   begin mem_req = 1'b1; mem_addr = cur + AW'(fi); end
            ST_SRC_RD:  begin mem_req = 1'b1; mem_addr = d_src[sidx[SW-1:0]] + widx; end
            ST_DST_WR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = d_dst + widx; mem_wdata = acc; end
            ST_STAT_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur;
                mem_wdata = swap ? bswap32({1'b0, d_stat[30:0]}) : {1'b0, d_stat[30:0]};
            end
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign cur_desc = cur;
    assign eoc      = eoc_q;

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R8
    eoc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> !busy && $past(busy));
    // R8
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);
    // R6
    stat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_addr == cur) && !swap && (state == ST_STAT_WR)) |-> !mem_wdata[31]);
endmodule

// File: rtl/xorchain_dma.sv
module xorchain_dma #(
    parameter int AW   = 16,
    parameter int NSRC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          eoc
);
    logic          busy, swap, start;
    logic [2:0]    mode;
    logic [AW-1:0] head, cur_desc;

    xc_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .cur_desc(cur_desc), .mode(mode), .swap(swap), .head(head), .start(start));

    xc_engine #(.AW(AW), .NSRC(NSRC)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .head(head), .mode(mode),
        .swap(swap), .busy(busy), .cur_desc(cur_desc), .eoc(eoc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));
endmodule

// File: tb/sim_xorchain_dma.sv
`timescale 1ns/1ps
module sim_xorchain_dma;
    localparam int AW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_we, mem_ack, eoc;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #4 clk = ~clk;   // 125 MHz

    xorchain_dma #(.AW(AW), .NSRC(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .eoc(eoc));

    logic [31:0] mem  [0:4095];
    logic [31:0] expv [0:4095];
    bit          expd [0:4095];
    int checks = 0, errors = 0, wr_chk = 0, wr_err = 0, hs_chk = 0, hs_err = 0;
    int eoc_cnt = 0, last_exp = 0;
    string req_tag = "R1";
    bit done = 0;

    function automatic logic [31:0] sw32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // memory model; every write is compared with the model on its clock
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                wr_chk++;
                if (!expd[mem_addr[11:0]] || expv[mem_addr[11:0]] !== mem_wdata) begin
                    wr_err++;
                    $display("FAIL %s write @%0h actual %08h expected %08h", req_tag,
                             mem_addr, mem_wdata, expd[mem_addr[11:0]] ? expv[mem_addr[11:0]] : 32'hx);
                end
                mem[mem_addr[11:0]] <= mem_wdata;
            end else mem_rdata <= mem[mem_addr[11:0]];
        end else mem_ack <= 1'b0;
        if (rst_n && eoc) eoc_cnt++;
    end

    // R13 handshake hold, observed between edges
    bit p_pend = 0;
    logic [AW-1:0] p_addr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_pend) begin
                hs_chk++;
                if (!mem_req || mem_addr !== p_addr) begin
                    hs_err++;
                    $display("FAIL R13 req/addr actual %0b/%0h expected 1/%0h", mem_req, mem_addr, p_addr);
                end
            end
            p_pend = mem_req && !mem_ack;
            p_addr = mem_addr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int base, input bit sw, input logic [31:0] st,
                            input logic [31:0] cmd, input logic [31:0] nxt,
                            input logic [31:0] len, input logic [31:0] dst,
                            input logic [31:0] s0, input logic [31:0] sstep);
        logic [31:0] w [13];
        w[0] = st; w[1] = cmd; w[2] = nxt; w[3] = len; w[4] = dst;
        for (int i = 0; i < 8; i++) w[5+i] = s0 + sstep * i;
        for (int i = 0; i < 13; i++) mem[base+i] = sw ? sw32(w[i]) : w[i];
    endtask

    // behavioural walk of the chain over the current memory image
    task automatic compute_expect(input int hd, input bit sw, input bit xm);
        int d = hd;
        for (int a = 0; a < 4096; a++) expd[a] = 0;
        forever begin
            logic [31:0] st, cmd, nx, ln, ds, v;
            st = sw ? sw32(mem[d]) : mem[d];
            last_exp = d;
            if (!st[31]) break;
            cmd = sw ? sw32(mem[d+1]) : mem[d+1];
            nx  = sw ? sw32(mem[d+2]) : mem[d+2];
            ln  = sw ? sw32(mem[d+3]) : mem[d+3];
            ds  = sw ? sw32(mem[d+4]) : mem[d+4];
            for (int j = 0; j < int'(ln >> 2); j++) begin
                v = 0;
                for (int i = 0; i < 8; i++) begin
                    logic [31:0] sa;
                    sa = sw ? sw32(mem[d+5+i]) : mem[d+5+i];
                    if (xm ? cmd[i] : (i == 0)) v ^= mem[sa + j];
                end
                expv[ds + j] = v; expd[ds + j] = 1;
            end
            expv[d] = sw ? sw32({1'b0, st[30:0]}) : {1'b0, st[30:0]};
            expd[d] = 1;
            if (nx == 0) break;
            d = nx;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int n = 0; n < 20000; n++) begin
            reg_read(2'd1, r);
            if (r[5:4] == 2'b00) return;
        end
        chk({req_tag, " timeout"}, 1, 0);
    endtask

    task automatic finish_job(input string tag, input int e0);
        logic [31:0] r;
        int bad = 0;
        for (int a = 0; a < 4096; a++) if (expd[a] && mem[a] !== expv[a]) bad++;
        chk({tag, " memory image"}, bad, 0);
        reg_read(2'd3, r);
        chk("R7 current descriptor", r, last_exp);
        chk("R8 eoc count", eoc_cnt - e0, 1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors",
                     checks + wr_chk + hs_chk, errors + wr_err + hs_err);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        summary();
    end

    initial begin
        logic [31:0] r;
        int e0;
        for (int a = 0; a < 4096; a++) begin mem[a] = 32'hDEADBEEF; expd[a] = 0; end
        for (int j = 0; j < 8; j++) mem[12'h400 + j] = 32'hC0DE0000 + j;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 4; j++)
                mem[12'h600 + 16*i + j] = (32'h01010101 * (i + 1)) ^ (j << 20) ^ 32'h5A000000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd1, r); chk("R1 activation", r, 0);
        reg_read(2'd3, r); chk("R1 current", r, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 eoc", eoc, 0);

        // R4 R6 copy, single descriptor
        req_tag = "R4";
        put_desc(12'h100, 0, 32'h80000011, 32'h80000000, 0, 16, 12'h500, 12'h400, 0);
        compute_expect(12'h100, 0, 0);
        reg_write(2'd0, 0); reg_write(2'd2, 12'h100);
        e0 = eoc_cnt;
        reg_write(2'd1, 1);
        wait_idle();
        finish_job("R4", e0);
        chk("R6 status released", mem[12'h100], 32'h00000011);

        // R3 R5 XOR chain of three: all sources, bitmap 0x05, empty bitmap
        req_tag = "R5";
        put_desc(12'h200, 0, 32'h80000000, 32'h800000FF, 12'h220, 12, 12'h700, 12'h600, 16);
        put_desc(12'h220, 0, 32'h80000001, 32'h80000005, 12'h240, 8, 12'h710, 12'h600, 16);
        put_desc(12'h240, 0, 32'h80000002, 32'h80000000, 0, 8, 12'h720, 12'h600, 16);
        compute_expect(12'h240, 0, 1);
        compute_expect(12'h200, 0, 1);
        reg_write(2'd0, 1); reg_write(2'd2, 12'h200);
        e0 = eoc_cnt;
        reg_write(2'd1, 1);
        reg_read(2'd1, r); chk("R2 busy state", r, 32'h10);
        // R10 writes during the run
        reg_write(2'd2, 12'h999); reg_write(2'd0, 0); reg_write(2'd1, 1);
        wait_idle();
        reg_read(2'd1, r); chk("R2 idle state", r, 0);
        finish_job("R5", e0);
        chk("R5 empty bitmap zero", mem[12'h720], 0);
        reg_read(2'd0, r); chk("R10 config kept", r, 1);
        reg_read(2'd2, r); chk("R10 head kept", r, 32'h200);

        // R9 descriptor not owned
        req_tag = "R9";
        put_desc(12'h300, 0, 32'h00000007, 32'h80000000, 0, 8, 12'h780, 12'h400, 0);
        compute_expect(12'h300, 0, 0);
        reg_write(2'd0, 0); reg_write(2'd2, 12'h300);
        e0 = eoc_cnt;
        reg_write(2'd1, 1);
        wait_idle();
        finish_job("R9", e0);
        chk("R9 status untouched", mem[12'h300], 32'h00000007);
        chk("R9 dest untouched", mem[12'h780], 32'hDEADBEEF);

        // R12 zero length
        req_tag = "R12";
        put_desc(12'h320, 0, 32'h80000123, 32'h80000000, 0, 0, 12'h790, 12'h400, 0);
        compute_expect(12'h320, 0, 0);
        reg_write(2'd2, 12'h320);
        e0 = eoc_cnt;
        reg_write(2'd1, 1);
        wait_idle();
        finish_job("R12", e0);
        chk("R12 status", mem[12'h320], 32'h00000123);
        chk("R12 dest untouched", mem[12'h790], 32'hDEADBEEF);

        // R11 swapped descriptor words, copy mode
        req_tag = "R11";
        put_desc(12'h340, 1, 32'h80000042, 32'h80000000, 0, 16, 12'h7A0, 12'h400, 0);
        compute_expect(12'h340, 1, 0);
        reg_write(2'd0, 32'h8); reg_write(2'd2, 12'h340);
        e0 = eoc_cnt;
        reg_write(2'd1, 1);
        wait_idle();
        finish_job("R11", e0);
        chk("R11 status swapped", mem[12'h340], 32'h42000000);
        chk("R11 data unswapped", mem[12'h7A3], 32'hC0DE0003);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule